// File: doc/BRIEF.md
# Register Semaphore Dependency Scoreboard

This block sits in an in-order decode stage that reads its operands from a private copy of the general register file. The execute stage returns results into that copy over a writeback port. For every register the block keeps a small counter of results still in flight toward it. A dispatched instruction that reads a register in decode may leave only when the counters of all the registers it reads are zero.

An instruction that produces a register result (arithmetic or load) raises the counter of its destination when it issues. Each writeback lowers the counter of the register it writes. Because the counters count rather than flag, several writes to one register can be in flight at the same time. A reader then waits for all of them to land. The decode stage holds a stalled request steady. Once it clears, the request issues in a single cycle, and the operand values appear on the read outputs in that same cycle.

Top module: `reg_sema_scoreboard`

## Requirements
- R1: After reset every counter is zero and every register of the copy holds zero, so any dispatch issues at once and reads zero.
- R2: Issuing an arithmetic instruction (class 0) or a load (class 1) raises the destination counter by one, so a later reader of that register stalls.
- R3: A writeback stores its value into the copy and lowers that register's counter by one; a writeback to a register whose counter is zero is an error.
- R4: Several results may be in flight for one register; a reader waits until a writeback has arrived for each of them.
- R5: Class codes and source usage: load (1) needs a and b; store (2) needs a, b and c; conditional branch (3) needs a and b; register jump (4) needs a; offset jump (5) and arithmetic (0) need none. Unneeded source fields never cause a stall.
- R6: A store raises no counter, whatever its destination field holds.
- R7: A writeback and an issuing producer that target the same register in one cycle leave its counter unchanged.
- R8: A counter never passes CNT_MAX: a producer whose destination counter is at CNT_MAX stalls, unless a writeback to that register lands in the same cycle.
- R9: Issue and stall are combinational from the request: issue = valid and ready, stall = valid and not ready, never both. Register 0 is tracked like any other register.
- R10: The three read outputs show, in the same cycle, the copy contents at source indices a, b and c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | A decoded instruction is offered |
| disp_class | input | 3 | Instruction class code (see R5) |
| disp_dst | input | RW | Destination register index |
| disp_src_a | input | RW | Source register a |
| disp_src_b | input | RW | Source register b |
| disp_src_c | input | RW | Source register c |
| disp_issue | output | 1 | The offered instruction leaves this cycle |
| disp_stall | output | 1 | The offered instruction must wait |
| wb_valid | input | 1 | A result arrives from execute |
| wb_reg | input | RW | Register written by the result |
| wb_data | input | DW | Result value |
| rd_a_data | output | DW | Copy contents at source a |
| rd_b_data | output | DW | Copy contents at source b |
| rd_c_data | output | DW | Copy contents at source c |

## Verification
Issue, stall and the three read outputs are due in the same cycle as the request that produces them. Counter changes and copy writes show only after the next rising edge, through the issue of a later request. The bench therefore drives each step on the falling edge and samples one time unit later, before the edge that commits the step. Each expected value accounts for the state committed by all earlier steps, and same-cycle writeback cases expect the old counter value to govern the request.

// File: rtl/sb_pkg.sv
package sb_pkg;

    typedef enum logic [2:0] {
        CL_ARITH  = 3'd0,
        CL_LOAD   = 3'd1,
        CL_STORE  = 3'd2,
        CL_BRANCH = 3'd3,
        CL_JREG   = 3'd4,
        CL_JOFF   = 3'd5
    } instr_class_e;

    typedef struct packed {
        logic use_a;
        logic use_b;
        logic use_c;
        logic produces;
    } need_t;

    // Which sources a class reads in decode, and whether it writes a register.
    function automatic need_t class_need(input logic [2:0] cls);
        need_t n;
        n = '0;
        case (cls)
            CL_ARITH:  n.produces = 1'b1;
            CL_LOAD:   begin n.use_a = 1'b1; n.use_b = 1'b1; n.produces = 1'b1; end
            CL_STORE:  begin n.use_a = 1'b1; n.use_b = 1'b1; n.use_c = 1'b1; end
            CL_BRANCH: begin n.use_a = 1'b1; n.use_b = 1'b1; end
            CL_JREG:   n.use_a = 1'b1;
            default:   n = '0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/sb_counter_bank.sv
module sb_counter_bank #(
    parameter int NREGS   = 16,
    parameter int CNT_MAX = 3,
    localparam int RW = $clog2(NREGS),
    localparam int CW = $clog2(CNT_MAX + 1)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          inc_en,
    input  logic [RW-1:0]                 inc_idx,
    input  logic                          dec_en,
    input  logic [RW-1:0]                 dec_idx,
    output logic [NREGS-1:0][CW-1:0]      cnt
);

    for (genvar i = 0; i < NREGS; i++) begin : g_cnt
        logic up;
        logic down;
        logic [CW-1:0] q;

        assign up   = inc_en && (inc_idx == RW'(i));
        assign down = dec_en && (dec_idx == RW'(i)) && (q != '0);

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else begin
                case ({up, down})
                    2'b10:   q <= q + 1'b1;
                    2'b01:   q <= q - 1'b1;
                    default: q <= q;
                endcase
            end
        end

        assign cnt[i] = q;
    end

endmodule

// File: rtl/sb_regcopy.sv
module sb_regcopy #(
    parameter int NREGS = 16,
    parameter int DW    = 32,
    localparam int RW = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [RW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [RW-1:0] rd_idx_a,
    input  logic [RW-1:0] rd_idx_b,
    input  logic [RW-1:0] rd_idx_c,
    output logic [DW-1:0] rd_a,
    output logic [DW-1:0] rd_b,
    output logic [DW-1:0] rd_c
);

    logic [NREGS-1:0][DW-1:0] regs;

    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[i] <= '0;
            end else if (wr_en && (wr_idx == RW'(i))) begin
                regs[i] <= wr_data;
            end
        end
    end

    assign rd_a = regs[rd_idx_a];
    assign rd_b = regs[rd_idx_b];
    assign rd_c = regs[rd_idx_c];

endmodule

// File: rtl/sb_issue_ctl.sv
module sb_issue_ctl
    import sb_pkg::*;
#(
    parameter int NREGS   = 16,
    parameter int CNT_MAX = 3,
    localparam int RW = $clog2(NREGS),
    localparam int CW = $clog2(CNT_MAX + 1)
) (
    input  logic                     req_valid,
    input  logic [2:0]               req_class,
    input  logic [RW-1:0]            req_dst,
    input  logic [RW-1:0]            req_a,
    input  logic [RW-1:0]            req_b,
    input  logic [RW-1:0]            req_c,
    input  logic [NREGS-1:0][CW-1:0] cnt,
    input  logic                     wb_valid,
    input  logic [RW-1:0]            wb_reg,
    output logic                     issue,
    output logic                     stall,
    output logic                     inc_en
);

    need_t need;
    logic  a_ok, b_ok, c_ok, room_ok, ready;

    always_comb begin
        need    = class_need(req_class);
        a_ok    = !need.use_a || (cnt[req_a] == '0);
        b_ok    = !need.use_b || (cnt[req_b] == '0);
        c_ok    = !need.use_c || (cnt[req_c] == '0);
        room_ok = !need.produces
               || (cnt[req_dst] != CW'(CNT_MAX))
               || (wb_valid && (wb_reg == req_dst));
        ready   = a_ok && b_ok && c_ok && room_ok;
        issue   = req_valid && ready;
        stall   = req_valid && !ready;
        inc_en  = issue && need.produces;
    end

endmodule

// File: rtl/reg_sema_scoreboard.sv
module reg_sema_scoreboard #(
    parameter int NREGS   = 16,
    parameter int DW      = 32,
    parameter int CNT_MAX = 3,
    localparam int RW = $clog2(NREGS),
    localparam int CW = $clog2(CNT_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          disp_valid,
    input  logic [2:0]    disp_class,
    input  logic [RW-1:0] disp_dst,
    input  logic [RW-1:0] disp_src_a,
    input  logic [RW-1:0] disp_src_b,
    input  logic [RW-1:0] disp_src_c,
    output logic          disp_issue,
    output logic          disp_stall,
    input  logic          wb_valid,
    input  logic [RW-1:0] wb_reg,
    input  logic [DW-1:0] wb_data,
    output logic [DW-1:0] rd_a_data,
    output logic [DW-1:0] rd_b_data,
    output logic [DW-1:0] rd_c_data
);

    logic [NREGS-1:0][CW-1:0] cnt_q;
    logic                     inc_en;

    sb_issue_ctl #(.NREGS(NREGS), .CNT_MAX(CNT_MAX)) u_ctl (
        .req_valid (disp_valid),
        .req_class (disp_class),
        .req_dst   (disp_dst),
        .req_a     (disp_src_a),
        .req_b     (disp_src_b),
        .req_c     (disp_src_c),
        .cnt       (cnt_q),
        .wb_valid  (wb_valid),
        .wb_reg    (wb_reg),
        .issue     (disp_issue),
        .stall     (disp_stall),
        .inc_en    (inc_en)
    );

    sb_counter_bank #(.NREGS(NREGS), .CNT_MAX(CNT_MAX)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .inc_en  (inc_en),
        .inc_idx (disp_dst),
        .dec_en  (wb_valid),
        .dec_idx (wb_reg),
        .cnt     (cnt_q)
    );

    sb_regcopy #(.NREGS(NREGS), .DW(DW)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wb_valid),
        .wr_idx   (wb_reg),
        .wr_data  (wb_data),
        .rd_idx_a (disp_src_a),
        .rd_idx_b (disp_src_b),
        .rd_idx_c (disp_src_c),
        .rd_a     (rd_a_data),
        .rd_b     (rd_b_data),
        .rd_c     (rd_c_data)
    );

endmodule

// File: rtl/sb_checker.sv
module sb_checker
    import sb_pkg::*;
#(
    parameter int NREGS   = 16,
    parameter int CNT_MAX = 3,
    localparam int RW = $clog2(NREGS),
    localparam int CW = $clog2(CNT_MAX + 1)
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     disp_valid,
    input logic [2:0]               disp_class,
    input logic [RW-1:0]            disp_dst,
    input logic [RW-1:0]            disp_src_a,
    input logic [RW-1:0]            disp_src_b,
    input logic [RW-1:0]            disp_src_c,
    input logic                     disp_issue,
    input logic                     disp_stall,
    input logic                     wb_valid,
    input logic [RW-1:0]            wb_reg,
    input logic [NREGS-1:0][CW-1:0] cnt
);

    need_t nd;
    logic  prod_iss, same_reg;

    always_comb begin
        nd       = class_need(disp_class);
        prod_iss = disp_issue && nd.produces;
        same_reg = wb_valid && (wb_reg == disp_dst);
    end

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> cnt[wb_reg] != '0); // R3

    AST_DEC_STEP: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && !(prod_iss && same_reg)) |=>
        cnt[$past(wb_reg)] == CW'($past(cnt[wb_reg]) - 1'b1)); // R3

    AST_INC_STEP: assert property (@(posedge clk) disable iff (rst)
        (prod_iss && !same_reg) |=>
        cnt[$past(disp_dst)] == CW'($past(cnt[disp_dst]) + 1'b1)); // R2

    AST_SRC_CLEAR: assert property (@(posedge clk) disable iff (rst)
        disp_issue |-> ((!nd.use_a || cnt[disp_src_a] == '0)
                     && (!nd.use_b || cnt[disp_src_b] == '0)
                     && (!nd.use_c || cnt[disp_src_c] == '0))); // R5

    AST_STORE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (disp_issue && disp_class == CL_STORE && !wb_valid) |=> $stable(cnt)); // R6

    AST_NET_ZERO: assert property (@(posedge clk) disable iff (rst)
        (prod_iss && same_reg) |=> cnt[$past(disp_dst)] == $past(cnt[disp_dst])); // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (prod_iss && cnt[disp_dst] == CW'(CNT_MAX)) |-> same_reg); // R8

    AST_ISSUE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(disp_issue && disp_stall) && ((disp_issue || disp_stall) == disp_valid)); // R9

endmodule

bind reg_sema_scoreboard sb_checker #(.NREGS(NREGS), .CNT_MAX(CNT_MAX)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .disp_valid (disp_valid),
    .disp_class (disp_class),
    .disp_dst   (disp_dst),
    .disp_src_a (disp_src_a),
    .disp_src_b (disp_src_b),
    .disp_src_c (disp_src_c),
    .disp_issue (disp_issue),
    .disp_stall (disp_stall),
    .wb_valid   (wb_valid),
    .wb_reg     (wb_reg),
    .cnt        (cnt_q)
);

// File: tb/reg_sema_scoreboard_test.sv
module reg_sema_scoreboard_test;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 40;

    typedef struct packed {
        logic        v;
        logic [2:0]  cls;
        logic [3:0]  d, a, b, c;
        logic        wv;
        logic [3:0]  wr;
        logic [31:0] wd;
        logic        ei;
        logic        ck;
        logic [31:0] ea, eb, ec;
        logic [3:0]  rq;
    } vec_t;

    // fields: v cls dst a b c | wv wr wd | exp_issue chk_rd ea eb ec | req
    localparam vec_t VEC [NV] = '{
        '{1,0, 2,0,0,0, 0, 0,32'h00, 1,0,32'h00,0,0, 2},  // R2 producer of r2 issues
        '{1,3, 0,2,3,0, 0, 0,32'h00, 0,0,32'h00,0,0, 2},  // R2 branch reading r2 stalls
        '{1,3, 0,2,3,0, 1, 2,32'h55, 0,0,32'h00,0,0, 3},  // R3 old count governs this cycle
        '{1,3, 0,2,3,0, 0, 0,32'h00, 1,1,32'h55,0,0, 3},  // R3 issue with new value
        '{1,1, 5,1,1,0, 0, 0,32'h00, 1,0,32'h00,0,0, 4},  // R4 first load to r5
        '{1,1, 5,1,1,0, 0, 0,32'h00, 1,0,32'h00,0,0, 4},  // R4 second load to r5
        '{1,4, 0,5,0,0, 0, 0,32'h00, 0,0,32'h00,0,0, 4},  // R4 jump via r5 waits
        '{1,4, 0,5,0,0, 1, 5,32'h11, 0,0,32'h00,0,0, 4},  // R4
        '{1,4, 0,5,0,0, 1, 5,32'h22, 0,0,32'h00,0,0, 4},  // R4 one still pending
        '{1,4, 0,5,0,0, 0, 0,32'h00, 1,1,32'h22,0,0, 4},  // R4 both landed
        '{1,2, 7,1,4,7, 0, 0,32'h00, 1,0,32'h00,0,0, 6},  // R6 store with dst field 7
        '{1,4, 0,7,0,0, 0, 0,32'h00, 1,0,32'h00,0,0, 6},  // R6 r7 not busy
        '{1,0, 9,0,0,0, 0, 0,32'h00, 1,0,32'h00,0,0, 5},  // R5 make r9 busy
        '{1,5, 0,9,9,9, 0, 0,32'h00, 1,0,32'h00,0,0, 5},  // R5 offset jump reads none
        '{1,0,10,9,9,9, 0, 0,32'h00, 1,0,32'h00,0,0, 5},  // R5 arithmetic reads none
        '{1,2, 0,0,0,9, 0, 0,32'h00, 0,0,32'h00,0,0, 5},  // R5 store needs c
        '{1,3, 0,0,9,0, 0, 0,32'h00, 0,0,32'h00,0,0, 5},  // R5 branch needs b
        '{1,1,11,0,9,0, 0, 0,32'h00, 0,0,32'h00,0,0, 5},  // R5 load needs b
        '{1,1,11,0,0,9, 0, 0,32'h00, 1,0,32'h00,0,0, 5},  // R5 load ignores c
        '{1,3, 0,0,0,9, 0, 0,32'h00, 1,0,32'h00,0,0, 5},  // R5 branch ignores c
        '{1,4, 0,0,9,9, 0, 0,32'h00, 1,0,32'h00,0,0, 5},  // R5 reg jump ignores b,c
        '{1,0, 9,0,0,0, 1, 9,32'h99, 1,0,32'h00,0,0, 7},  // R7 inc+dec same reg
        '{0,0, 0,0,0,0, 1, 9,32'hAA, 0,0,32'h00,0,0, 7},  // R7 last writeback
        '{1,4, 0,9,0,0, 0, 0,32'h00, 1,1,32'hAA,0,0, 7},  // R7 count back at zero
        '{1,0,12,0,0,0, 0, 0,32'h00, 1,0,32'h00,0,0, 8},  // R8 count 1
        '{1,0,12,0,0,0, 0, 0,32'h00, 1,0,32'h00,0,0, 8},  // R8 count 2
        '{1,0,12,0,0,0, 0, 0,32'h00, 1,0,32'h00,0,0, 8},  // R8 count 3 = max
        '{1,0,12,0,0,0, 0, 0,32'h00, 0,0,32'h00,0,0, 8},  // R8 full, stall
        '{1,0,12,0,0,0, 1,12,32'h12, 1,0,32'h00,0,0, 8},  // R8 full but wb lands
        '{1,0,12,0,0,0, 0, 0,32'h00, 0,0,32'h00,0,0, 8},  // R8 still full
        '{0,0, 0,0,0,0, 1,12,32'h13, 0,0,32'h00,0,0, 8},  // R8 drain
        '{0,0, 0,0,0,0, 1,12,32'h14, 0,0,32'h00,0,0, 8},  // R8 drain
        '{0,0, 0,0,0,0, 1,12,32'h15, 0,0,32'h00,0,0, 8},  // R8 drain
        '{1,4, 0,12,0,0,0, 0,32'h00, 1,1,32'h15,0,0, 8},  // R8 drained
        '{1,0, 0,0,0,0, 0, 0,32'h00, 1,0,32'h00,0,0, 9},  // R9 producer of r0
        '{1,4, 0,0,0,0, 0, 0,32'h00, 0,0,32'h00,0,0, 9},  // R9 r0 tracked
        '{1,4, 0,0,0,0, 1, 0,32'h77, 0,0,32'h00,0,0, 9},  // R9
        '{1,4, 0,0,0,0, 0, 0,32'h00, 1,1,32'h77,32'h77,32'h77, 9}, // R9
        '{1,2, 0,2,5,12,0, 0,32'h00, 1,1,32'h55,32'h22,32'h15, 10}, // R10
        '{1,3, 0,9,0,2, 0, 0,32'h00, 1,1,32'hAA,32'h77,32'h55, 10}  // R10
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        disp_valid = 1'b0;
    logic [2:0]  disp_class = '0;
    logic [3:0]  disp_dst = '0, disp_src_a = '0, disp_src_b = '0, disp_src_c = '0;
    logic        disp_issue, disp_stall;
    logic        wb_valid = 1'b0;
    logic [3:0]  wb_reg = '0;
    logic [31:0] wb_data = '0;
    logic [31:0] rd_a_data, rd_b_data, rd_c_data;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    reg_sema_scoreboard uut (
        .clk(clk), .rst(rst),
        .disp_valid(disp_valid), .disp_class(disp_class), .disp_dst(disp_dst),
        .disp_src_a(disp_src_a), .disp_src_b(disp_src_b), .disp_src_c(disp_src_c),
        .disp_issue(disp_issue), .disp_stall(disp_stall),
        .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_data(wb_data),
        .rd_a_data(rd_a_data), .rd_b_data(rd_b_data), .rd_c_data(rd_c_data)
    );

    task automatic check_flag(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic check_word(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [2:0] cls, input logic [3:0] d,
                         input logic [3:0] a, input logic [3:0] b, input logic [3:0] c,
                         input logic wv, input logic [3:0] wr, input logic [31:0] wd);
        @(negedge clk);
        disp_valid = v; disp_class = cls; disp_dst = d;
        disp_src_a = a; disp_src_b = b; disp_src_c = c;
        wb_valid = wv; wb_reg = wr; wb_data = wd;
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        drive(0, 0, 0, 3, 4, 5, 0, 0, 0);
        rst = 1'b0;
        // R1 reset state: idle, copy reads zero
        check_flag("R1 idle issue", disp_issue, 1'b0);
        check_flag("R1 idle stall", disp_stall, 1'b0);
        check_word("R1 rd_a after reset", rd_a_data, 32'h0);
        check_word("R1 rd_c after reset", rd_c_data, 32'h0);

        for (int k = 0; k < NV; k++) begin
            drive(VEC[k].v, VEC[k].cls, VEC[k].d, VEC[k].a, VEC[k].b, VEC[k].c,
                  VEC[k].wv, VEC[k].wr, VEC[k].wd);
            n_checks++;
            if (disp_issue !== VEC[k].ei || disp_stall !== (VEC[k].v & ~VEC[k].ei)) begin
                n_fail++;
                $display("FAIL R%0d step %0d issue/stall actual=%0b/%0b expected=%0b/%0b",
                         VEC[k].rq, k, disp_issue, disp_stall, VEC[k].ei, VEC[k].v & ~VEC[k].ei);
            end
            if (VEC[k].ck) begin
                n_checks++;
                if (rd_a_data !== VEC[k].ea || rd_b_data !== VEC[k].eb || rd_c_data !== VEC[k].ec) begin
                    n_fail++;
                    $display("FAIL R%0d step %0d read actual=%h/%h/%h expected=%h/%h/%h",
                             VEC[k].rq, k, rd_a_data, rd_b_data, rd_c_data,
                             VEC[k].ea, VEC[k].eb, VEC[k].ec);
                end
            end
        end

        // R1 reset mid-run clears counters (r10, r11 still pending) and the copy
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
        rst = 1'b1;
        @(posedge clk);
        drive(1, 4, 0, 10, 11, 2, 0, 0, 0);
        rst = 1'b0;
        drive(1, 3, 0, 10, 11, 2, 0, 0, 0);
        check_flag("R1 branch on r10/r11 after reset", disp_issue, 1'b1);
        check_word("R1 rd_a r10 cleared", rd_a_data, 32'h0);
        check_word("R1 rd_c r2 cleared", rd_c_data, 32'h0);

        // R7 net change at max: r3 to 3, then producer + writeback keeps 3
        drive(1, 0, 3, 0, 0, 0, 0, 0, 0);
        drive(1, 0, 3, 0, 0, 0, 0, 0, 0);
        drive(1, 0, 3, 0, 0, 0, 0, 0, 0);
        drive(1, 0, 3, 0, 0, 0, 1, 3, 32'h31);
        check_flag("R7 producer at max with wb", disp_issue, 1'b1);
        drive(1, 1, 3, 0, 0, 0, 0, 0, 0);
        check_flag("R8 load to full r3 stalls", disp_stall, 1'b1);
        drive(0, 0, 0, 0, 0, 0, 1, 3, 32'h32);
        drive(0, 0, 0, 0, 0, 0, 1, 3, 32'h33);
        drive(1, 4, 0, 3, 0, 0, 1, 3, 32'h34);
        check_flag("R4 r3 busy while last wb lands", disp_stall, 1'b1);
        drive(1, 4, 0, 3, 0, 0, 0, 0, 0);
        check_flag("R4 r3 free after three wb", disp_issue, 1'b1);
        check_word("R3 r3 holds last value", rd_a_data, 32'h34);
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule